// File: doc/BRIEF.md
# Parallel Bus Phase Sequencer

This block tracks which phase a shared parallel peripheral bus is in. Up to eight devices share the bus, and the host adapter is one of them. The block moves the bus from idle, through an ID-based contest for ownership, into a connect phase and then into the transfer phases that the connected target picks. It leaves those phases on a target disconnect, a connect timeout or a global bus reset.

Each request slot presents a valid bit and the ID that the device claims. When the contest ends, the highest unique in-range ID takes the bus. The winner also gives the ID of the peer it wants to reach, and a flag that marks the connection as a reconnection from a target back to its initiator.

Top module: `bus_phase_seq`

## Requirements
- R1: After reset, `phase` is 0 (idle). In idle, the block enters the contest phase (1) on the next cycle only if at least one eligible request is present. Otherwise it stays idle.
- R2: Requests present in any phase other than idle do not start a contest. The phase they arrive in continues unchanged.
- R3: The contest phase lasts ARB_CYC cycles. On its last cycle, the highest eligible ID is latched into `owner_id` and `peer_target` is latched into `peer_id`. The bus then enters the connect phase (2).
- R4: A claimed ID of NDEV or above, or an ID claimed by more than one valid slot, is not eligible. If no request is eligible on the last contest cycle, the bus returns to idle.
- R5: If `reconnect` is high on the last contest cycle, the bus enters the reconnect phase (3) instead of the connect phase (2).
- R6: In phase 2 or phase 3, `tgt_req` moves the bus to transfer phase 4 + `tgt_phase`. The codes are 0 command (4), 1 data (5), 2 status (6) and 3 message (7).
- R7: If phase 2 or phase 3 lasts SEL_TO cycles with no `tgt_req`, the bus returns to idle.
- R8: In the transfer phases (4 to 7), `tgt_req` moves the bus to 4 + `tgt_phase`. Without `tgt_req`, the phase holds.
- R9: `tgt_disc` ends the connection, and the bus goes idle on the next cycle, only in the message phase (7), where it wins over `tgt_req`. In any other phase it has no effect.
- R10: `bus_rst` forces the bus idle on the next cycle from any phase and clears `owner_id` and `peer_id`. It overrides every other input.
- R11: Whenever `phase` is idle, `owner_id` and `peer_id` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Synchronous global bus reset |
| req_valid | input | NDEV | Per-slot contest request |
| req_id | input | NDEV*IDW | Per-slot claimed ID, slot s at bits s*IDW +: IDW |
| peer_target | input | log2(NDEV) | ID the winner connects to |
| reconnect | input | 1 | Winner is a target reconnecting to its initiator |
| tgt_req | input | 1 | Target requests a transfer phase |
| tgt_phase | input | 2 | Requested transfer phase code |
| tgt_disc | input | 1 | Target disconnect |
| phase | output | 3 | Current bus phase |
| owner_id | output | log2(NDEV) | ID that owns the bus |
| peer_id | output | log2(NDEV) | ID that was connected to |

## Verification
The bench targets the eligibility corners. These are duplicate claims that mask a higher ID, out-of-range claims, and sets with no eligible request at all. A design that got these wrong would give the bus to a colliding or nonexistent device, or would start a contest that nobody can win. The bench also sends requests in the middle of a connection and sends a disconnect outside the message phase. A wrong design would restart the contest or drop the bus early. Finally, the bench counts the connect timeout exactly and lets a disconnect collide with a phase request, which would expose an off-by-one window or the wrong priority.

// File: rtl/bus_phase_seq.sv
module bus_phase_seq #(
  parameter int NDEV    = 8,
  parameter int IDW     = 4,
  parameter int ARB_CYC = 2,
  parameter int SEL_TO  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_rst,
  input  logic [NDEV-1:0]          req_valid,
  input  logic [NDEV*IDW-1:0]      req_id,
  input  logic [$clog2(NDEV)-1:0]  peer_target,
  input  logic                     reconnect,
  input  logic                     tgt_req,
  input  logic [1:0]               tgt_phase,
  input  logic                     tgt_disc,
  output logic [2:0]               phase,
  output logic [$clog2(NDEV)-1:0]  owner_id,
  output logic [$clog2(NDEV)-1:0]  peer_id
);
  localparam int OW = $clog2(NDEV);
  localparam int CW = $clog2(ARB_CYC + SEL_TO + 1);
  localparam logic [2:0] PH_IDLE = 3'd0, PH_ARB = 3'd1, PH_SEL = 3'd2,
                         PH_RESEL = 3'd3, PH_MSG = 3'd7;

  logic [NDEV-1:0] elig;
  logic            win_vld;
  logic [OW-1:0]   win_id;
  logic [CW-1:0]   cnt;
  wire  [2:0]      req_ph = {1'b1, tgt_phase};

  always_comb begin
    int hits;
    elig = '0;
    for (int k = 0; k < NDEV; k++) begin
      hits = 0;
      for (int s = 0; s < NDEV; s++)
        if (req_valid[s] && req_id[s*IDW +: IDW] == IDW'(k)) hits++;
      elig[k] = (hits == 1);
    end
  end

  always_comb begin
    win_vld = 1'b0;
    win_id  = '0;
    for (int k = 0; k < NDEV; k++)
      if (elig[k]) begin
        win_vld = 1'b1;
        win_id  = OW'(k);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      owner_id <= '0;
      peer_id  <= '0;
      cnt      <= '0;
    end else if (bus_rst) begin
      phase    <= PH_IDLE;
      owner_id <= '0;
      peer_id  <= '0;
      cnt      <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (win_vld) phase <= PH_ARB;
        end
        PH_ARB: begin
          if (cnt == CW'(ARB_CYC - 1)) begin
            cnt <= '0;
            if (win_vld) begin
              owner_id <= win_id;
              peer_id  <= peer_target;
              phase    <= reconnect ? PH_RESEL : PH_SEL;
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_SEL, PH_RESEL: begin
          if (tgt_req) begin
            phase <= req_ph;
            cnt   <= '0;
          end else if (cnt == CW'(SEL_TO - 1)) begin
            phase    <= PH_IDLE;
            owner_id <= '0;
            peer_id  <= '0;
            cnt      <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (phase == PH_MSG && tgt_disc) begin
            phase    <= PH_IDLE;
            owner_id <= '0;
            peer_id  <= '0;
          end else if (tgt_req) begin
            phase <= req_ph;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bus_phase_seq_chk.sv
module bus_phase_seq_chk #(
  parameter int NDEV   = 8,
  parameter int SEL_TO = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_rst,
  input logic                    tgt_disc,
  input logic [2:0]              phase,
  input logic [$clog2(NDEV)-1:0] owner_id,
  input logic [$clog2(NDEV)-1:0] peer_id
);
  localparam int TW = $clog2(SEL_TO + 2);
  logic [TW-1:0] sel_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sel_run <= '0;
    else if (phase == 3'd2 || phase == 3'd3) sel_run <= sel_run + 1'b1;
    else sel_run <= '0;

  AST_ARB_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != 3'd0 && phase != 3'd1) |=> (phase != 3'd1)); // R2
  AST_RESET_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (phase == 3'd0)); // R10
  AST_IDLE_CLEARS_IDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> (owner_id == '0 && peer_id == '0)); // R11
  AST_NO_EARLY_DISC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[2] && phase != 3'd7 && !bus_rst) |=> (phase != 3'd0)); // R9
  AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[2] && !bus_rst && !(phase == 3'd7 && tgt_disc)) |=> $stable(owner_id)); // R3
  AST_SEL_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    sel_run <= TW'(SEL_TO)); // R7
endmodule

bind bus_phase_seq bus_phase_seq_chk #(.NDEV(NDEV), .SEL_TO(SEL_TO)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .tgt_disc(tgt_disc),
  .phase(phase), .owner_id(owner_id), .peer_id(peer_id)
);

// File: tb/bus_phase_seq_tb.sv
module bus_phase_seq_tb;
  localparam int NDEV = 8, IDW = 4, ARB_CYC = 2, SEL_TO = 6, OW = 3;

  logic clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0;
  logic [NDEV-1:0] req_valid = '0;
  logic [NDEV*IDW-1:0] req_id = '0;
  logic [OW-1:0] peer_target = '0;
  logic reconnect = 1'b0, tgt_req = 1'b0, tgt_disc = 1'b0;
  logic [1:0] tgt_phase = '0;
  logic [2:0] phase;
  logic [OW-1:0] owner_id, peer_id;
  int n_cmp = 0, n_bad = 0;

  always #5 clk = ~clk;

  bus_phase_seq #(.NDEV(NDEV), .IDW(IDW), .ARB_CYC(ARB_CYC), .SEL_TO(SEL_TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .req_valid(req_valid), .req_id(req_id),
    .peer_target(peer_target), .reconnect(reconnect), .tgt_req(tgt_req),
    .tgt_phase(tgt_phase), .tgt_disc(tgt_disc), .phase(phase),
    .owner_id(owner_id), .peer_id(peer_id));

  function automatic logic [OW:0] exp_win(logic [NDEV-1:0] v, logic [NDEV*IDW-1:0] ids);
    logic [OW:0] r = '0;
    for (int k = 0; k < NDEV; k++) begin
      int h = 0;
      for (int s = 0; s < NDEV; s++)
        if (v[s] && ids[s*IDW +: IDW] == IDW'(k)) h++;
      if (h == 1) r = {1'b1, OW'(k)};
    end
    return r;
  endfunction

  function automatic logic [2:0] exp_next(logic [2:0] p, logic rq, logic [1:0] code, logic dc);
    if (p == 3'd7 && dc) return 3'd0;
    if (rq) return {1'b1, code};
    return p;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic clear_in;
    req_valid = '0; req_id = '0; reconnect = 1'b0;
    tgt_req = 1'b0; tgt_disc = 1'b0; bus_rst = 1'b0;
  endtask

  task automatic run_arb(logic [NDEV-1:0] v, logic [NDEV*IDW-1:0] ids,
                         logic [OW-1:0] tgt, logic rc, output logic won);
    logic [OW:0] w;
    w = exp_win(v, ids);
    req_valid = v; req_id = ids; peer_target = tgt; reconnect = rc;
    tick;
    if (!w[OW]) begin
      chk("R4 no eligible request", phase, 0);
      clear_in;
      won = 1'b0;
      return;
    end
    chk("R1 enter contest", phase, 1);
    for (int i = 1; i < ARB_CYC; i++) begin
      tick;
      chk("R3 contest length", phase, 1);
    end
    tick;
    chk(rc ? "R5 reconnect phase" : "R3 connect phase", phase, rc ? 3 : 2);
    chk("R3 owner", owner_id, w[OW-1:0]);
    chk("R3 peer", peer_id, tgt);
    clear_in;
    won = 1'b1;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary;
  end

  initial begin
    logic won;
    logic [2:0] ep;
    void'($urandom(32'd4242));
    #12 rst_n = 1'b1;
    #1;
    chk("R1 reset phase", phase, 0);
    chk("R11 reset owner", owner_id, 0);
    tick; tick;
    chk("R1 idle holds", phase, 0);

    run_arb(8'b0000_0111, {20'h0, 4'd1, 4'd6, 4'd3}, 3'd2, 1'b0, won);
    req_valid = 8'b1; req_id = {28'h0, 4'd7};
    tick;
    chk("R2 request during connect ignored", phase, 2);
    clear_in;
    for (int i = 2; i < SEL_TO; i++) begin
      tick;
      chk("R7 before timeout", phase, 2);
    end
    tick;
    chk("R7 timeout to idle", phase, 0);
    chk("R11 owner cleared", owner_id, 0);

    run_arb(8'b0000_0111, {20'h0, 4'd5, 4'd7, 4'd7}, 3'd1, 1'b0, won);
    chk("R4 duplicate masked", owner_id, 5);
    tgt_req = 1'b1; tgt_phase = 2'd0; tick; clear_in;
    bus_rst = 1'b1; tick; clear_in;
    chk("R10 reset from command", phase, 0);
    run_arb(8'b0000_0011, {24'h0, 4'd2, 4'd12}, 3'd4, 1'b0, won);
    chk("R4 out of range masked", owner_id, 2);
    bus_rst = 1'b1; tick; clear_in;
    run_arb(8'b0000_0011, {24'h0, 4'd9, 4'd9}, 3'd0, 1'b0, won);

    run_arb(8'b0000_0001, {28'h0, 4'd4}, 3'd6, 1'b1, won);
    tgt_req = 1'b1; tgt_phase = 2'd1; tick; clear_in;
    chk("R6 connect to data", phase, 5);
    tick;
    chk("R8 phase holds", phase, 5);
    tgt_disc = 1'b1; tick; clear_in;
    chk("R9 disconnect outside message ignored", phase, 5);
    tgt_req = 1'b1; tgt_phase = 2'd3; tick; clear_in;
    chk("R8 to message", phase, 7);
    tgt_req = 1'b1; tgt_phase = 2'd0; tgt_disc = 1'b1; tick; clear_in;
    chk("R9 disconnect wins", phase, 0);
    chk("R11 peer cleared", peer_id, 0);

    req_valid = 8'b1; req_id = {28'h0, 4'd3}; tick;
    bus_rst = 1'b1; tick; clear_in;
    chk("R10 reset during contest", phase, 0);

    for (int it = 0; it < 60; it++) begin
      logic [NDEV-1:0] v;
      logic [NDEV*IDW-1:0] ids;
      v = NDEV'($urandom);
      for (int s = 0; s < NDEV; s++) ids[s*IDW +: IDW] = IDW'($urandom_range(0, 11));
      run_arb(v, ids, OW'($urandom), 1'($urandom), won);
      if (!won) continue;
      tgt_req = 1'b1; tgt_phase = 2'($urandom);
      ep = {1'b1, tgt_phase};
      tick;
      chk("R6 first transfer phase", phase, ep);
      for (int st = 0; st < 8 && ep != 0; st++) begin
        tgt_req = 1'($urandom); tgt_phase = 2'($urandom); tgt_disc = 1'($urandom);
        ep = exp_next(ep, tgt_req, tgt_phase, tgt_disc);
        tick;
        chk("R8 R9 random walk", phase, ep);
      end
      clear_in;
      if (ep != 0) begin
        bus_rst = 1'b1; tick; clear_in;
        chk("R10 random reset", phase, 0);
      end
      chk("R11 idle ids", owner_id, 0);
    end
    summary;
  end
endmodule